// File: doc/BRIEF.md
# Instruction-Cycle Sequencer for an 8-bit Accumulator Machine

This block is the sequencing controller of a small 8-bit accumulator computer. The computer has a 256-byte memory that holds both program and data. A 4-bit step counter, decoded into sixteen one-hot timing lines, walks the datapath through a fixed sequence on every instruction:

- a display read of a switch-selected memory location;
- an opcode fetch;
- for memory-reference instructions, resolution of the operand address in direct or indirect mode, followed by the operand read.

Opcode-specific execution lives outside the block. It is reached through an `exec_start_o`/`exec_done_i` handshake.

Every datapath command leaves the block through a bank of registers, so each strobe lasts exactly one clock. Memory reads are synchronous: a read strobe in one cycle makes the data visible on the memory output in the following cycle. The bus source is encoded on `bus_sel_o` as 0 = display-address register, 1 = program counter, 2 = memory output, 3 = none. A halt input is sampled when an instruction completes. While the machine is stopped, only the display read repeats.

Top module: `icycle_ctrl`

## Requirements
- R1: While reset is asserted and after it, the step counter reads 0 and `t_o` equals 16'h0001; `t_o` always has exactly one bit set, and that bit is `t_o[step_o]`. The counter rises by one per clock and returns to 0 when an instruction completes.
- R2: Every instruction cycle starts with three commands. First, AR is loaded from the display-address register (`bus_sel_o`=0). Next, memory is read. Then the display-output register is loaded from the memory output (`bus_sel_o`=2). After this sequence the display output equals mem[display address]. It holds whether or not the machine is stopped.
- R3: The fetch loads AR from PC (`bus_sel_o`=1), then reads memory and increments PC in the same cycle, then loads IR from the memory output. At completion, IR holds mem[starting PC].
- R4: An opcode with bit 6 = 1 is a one-byte register-reference instruction, whatever bit 7 holds. It starts execution right after decode, with no operand-address read, and PC advances by exactly 1 over the instruction.
- R5: An opcode with bit 6 = 0 and bit 7 = 0 is a direct memory reference. At completion, AR = mem[PC+1], DR = mem[AR] and PC = starting PC + 2, with 8-bit wrap.
- R6: An opcode with bit 6 = 0 and bit 7 = 1 is an indirect memory reference. The second byte is treated as a pointer. At completion, AR = mem[mem[PC+1]], DR = mem[AR] and PC = starting PC + 2.
- R7: `halt_i` is sampled into the stop flag (`stopped_o`) when an instruction completes. While the flag is set, no PC increment and no IR load are issued, and the counter cycles through the display steps only. Once `halt_i` is low, the flag is re-sampled clear at the end of the display steps and fetching resumes from the held PC.
- R8: Each command strobe lasts one clock. At most one register-load strobe (AR, IR, DR, display output) is active in any cycle.
- R9: `exec_start_o` pulses for one clock while the counter is at step 15. The counter then holds at 15 until `exec_done_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Stop request, sampled at instruction end |
| ir_i | input | 8 | Current instruction register contents |
| exec_done_i | input | 1 | Executor finished the current opcode |
| bus_sel_o | output | 2 | Bus source: 0 display addr, 1 PC, 2 memory, 3 none |
| ld_ar_o | output | 1 | Load AR from bus |
| ld_ir_o | output | 1 | Load IR from bus |
| ld_dr_o | output | 1 | Load DR from bus |
| ld_outd_o | output | 1 | Load display-output register from bus |
| inc_pc_o | output | 1 | Increment PC |
| mem_rd_o | output | 1 | Synchronous memory read at AR |
| exec_start_o | output | 1 | Start opcode execution |
| step_o | output | 4 | Step counter value |
| t_o | output | 16 | One-hot timing lines |
| stopped_o | output | 1 | Stop flag |

## Verification
The assertions rely on a few properties of the inputs:

- `exec_done_i` is a single-cycle pulse that is raised only after a start.
- `ir_i` is stable from the IR load until the instruction completes, because only the block's own `ld_ir_o` changes it.
- `halt_i` matters only at the completion step.

The bench's executor stub raises done exactly three cycles after each start. Its datapath model changes IR solely on the block's load strobe. `halt_i` is changed only on falling edges, in the middle of a run.

// File: rtl/icc_pkg.sv
package icc_pkg;
  typedef enum logic [1:0] {
    BUS_DISP = 2'd0,
    BUS_PC   = 2'd1,
    BUS_MEM  = 2'd2,
    BUS_NONE = 2'd3
  } bus_sel_e;

  typedef struct packed {
    logic     ld_ar;
    logic     ld_ir;
    logic     ld_dr;
    logic     ld_outd;
    logic     inc_pc;
    logic     mem_rd;
    logic     exec_start;
    bus_sel_e bus;
  } cmd_t;

  localparam cmd_t CMD_IDLE = '{default: 1'b0, bus: BUS_NONE};

  // step assignment; sequence needs at least 16 steps
  localparam int ST_DSP_AR  = 0;
  localparam int ST_DSP_RD  = 1;
  localparam int ST_DSP_LD  = 2;
  localparam int ST_FET_AR  = 3;
  localparam int ST_FET_RD  = 4;
  localparam int ST_FET_IR  = 5;
  localparam int ST_OPA_AR  = 6;
  localparam int ST_DECODE  = 7;
  localparam int ST_OPA_LD  = 8;
  localparam int ST_OPR_RD  = 9;
  localparam int ST_OPR_LD  = 10;
  localparam int ST_IND_RD  = 11;
  localparam int ST_IND_LD  = 12;
  localparam int ST_WAIT    = 15;
endpackage

// File: rtl/icc_step_ctr.sv
module icc_step_ctr #(
  parameter int STEP_W = 4,
  localparam int NSTEP = 1 << STEP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STEP_W-1:0] nxt_i,
  output logic [STEP_W-1:0] step_o,
  output logic [NSTEP-1:0]  t_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_o <= '0;
    else         step_o <= nxt_i;
  end

  for (genvar i = 0; i < NSTEP; i++) begin : g_tdec
    assign t_o[i] = (step_o == STEP_W'(i));
  end
endmodule

// File: rtl/icc_cmd_decode.sv
module icc_cmd_decode
  import icc_pkg::*;
#(
  parameter int STEP_W  = 4,
  parameter int IR_W    = 8,
  parameter int REG_BIT = 6,
  parameter int IND_BIT = 7
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [IR_W-1:0]   ir_i,
  input  logic              stop_i,
  input  logic              exec_done_i,
  output cmd_t              cmd_o,
  output logic [STEP_W-1:0] nxt_o,
  output logic              stop_upd_o
);
  logic reg_ref, ind;
  assign reg_ref = ir_i[REG_BIT];
  assign ind     = ir_i[IND_BIT];

  always_comb begin
    cmd_o      = CMD_IDLE;
    nxt_o      = STEP_W'(step_i + 1'b1);
    stop_upd_o = 1'b0;
    case (int'(step_i))
      ST_DSP_AR: begin cmd_o.ld_ar = 1'b1; cmd_o.bus = BUS_DISP; end
      ST_DSP_RD: cmd_o.mem_rd = 1'b1;
      ST_DSP_LD: begin cmd_o.ld_outd = 1'b1; cmd_o.bus = BUS_MEM; end
      ST_FET_AR: begin
        if (stop_i) begin
          nxt_o      = '0;
          stop_upd_o = 1'b1;
        end else begin
          cmd_o.ld_ar = 1'b1;
          cmd_o.bus   = BUS_PC;
        end
      end
      ST_FET_RD: begin cmd_o.mem_rd = 1'b1; cmd_o.inc_pc = 1'b1; end
      ST_FET_IR: begin cmd_o.ld_ir = 1'b1; cmd_o.bus = BUS_MEM; end
      // IR not yet visible; preloading AR with PC is harmless for register refs
      ST_OPA_AR: begin cmd_o.ld_ar = 1'b1; cmd_o.bus = BUS_PC; end
      ST_DECODE: begin
        if (reg_ref) begin
          cmd_o.exec_start = 1'b1;
          nxt_o            = STEP_W'(ST_WAIT);
        end else begin
          cmd_o.mem_rd = 1'b1;
        end
      end
      ST_OPA_LD: begin cmd_o.ld_ar = 1'b1; cmd_o.bus = BUS_MEM; end
      ST_OPR_RD: begin cmd_o.mem_rd = 1'b1; cmd_o.inc_pc = !ind; end
      ST_OPR_LD: begin
        cmd_o.bus = BUS_MEM;
        if (ind) begin
          cmd_o.ld_ar = 1'b1;
        end else begin
          cmd_o.ld_dr      = 1'b1;
          cmd_o.exec_start = 1'b1;
          nxt_o            = STEP_W'(ST_WAIT);
        end
      end
      ST_IND_RD: begin cmd_o.mem_rd = 1'b1; cmd_o.inc_pc = 1'b1; end
      ST_IND_LD: begin
        cmd_o.ld_dr      = 1'b1;
        cmd_o.exec_start = 1'b1;
        cmd_o.bus        = BUS_MEM;
        nxt_o            = STEP_W'(ST_WAIT);
      end
      ST_WAIT: begin
        if (exec_done_i) begin
          nxt_o      = '0;
          stop_upd_o = 1'b1;
        end else begin
          nxt_o = step_i;
        end
      end
      default: nxt_o = STEP_W'(ST_WAIT);
    endcase
  end
endmodule

// File: rtl/icc_cmd_bank.sv
module icc_cmd_bank
  import icc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_t cmd_i,
  output cmd_t cmd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_o <= CMD_IDLE;
    else         cmd_o <= cmd_i;
  end
endmodule

// File: rtl/icycle_ctrl.sv
module icycle_ctrl
  import icc_pkg::*;
#(
  parameter int STEP_W  = 4,
  parameter int IR_W    = 8,
  parameter int REG_BIT = 6,
  parameter int IND_BIT = 7,
  localparam int NSTEP  = 1 << STEP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  input  logic [IR_W-1:0]   ir_i,
  input  logic              exec_done_i,
  output logic [1:0]        bus_sel_o,
  output logic              ld_ar_o,
  output logic              ld_ir_o,
  output logic              ld_dr_o,
  output logic              ld_outd_o,
  output logic              inc_pc_o,
  output logic              mem_rd_o,
  output logic              exec_start_o,
  output logic [STEP_W-1:0] step_o,
  output logic [NSTEP-1:0]  t_o,
  output logic              stopped_o
);
  logic [STEP_W-1:0] nxt;
  logic              stop_q, stop_upd;
  cmd_t              cmd_d, cmd_q;

  icc_step_ctr #(.STEP_W(STEP_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .nxt_i (nxt),
    .step_o(step_o),
    .t_o   (t_o)
  );

  icc_cmd_decode #(
    .STEP_W (STEP_W),
    .IR_W   (IR_W),
    .REG_BIT(REG_BIT),
    .IND_BIT(IND_BIT)
  ) u_dec (
    .step_i     (step_o),
    .ir_i       (ir_i),
    .stop_i     (stop_q),
    .exec_done_i(exec_done_i),
    .cmd_o      (cmd_d),
    .nxt_o      (nxt),
    .stop_upd_o (stop_upd)
  );

  icc_cmd_bank u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cmd_i (cmd_d),
    .cmd_o (cmd_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       stop_q <= 1'b0;
    else if (stop_upd) stop_q <= halt_i;
  end

  assign bus_sel_o    = cmd_q.bus;
  assign ld_ar_o      = cmd_q.ld_ar;
  assign ld_ir_o      = cmd_q.ld_ir;
  assign ld_dr_o      = cmd_q.ld_dr;
  assign ld_outd_o    = cmd_q.ld_outd;
  assign inc_pc_o     = cmd_q.inc_pc;
  assign mem_rd_o     = cmd_q.mem_rd;
  assign exec_start_o = cmd_q.exec_start;
  assign stopped_o    = stop_q;
endmodule

// File: rtl/icycle_ctrl_chk.sv
module icycle_ctrl_chk #(
  parameter int STEP_W = 4,
  localparam int NSTEP = 1 << STEP_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exec_done_i,
  input logic              ld_ar_o,
  input logic              ld_ir_o,
  input logic              ld_dr_o,
  input logic              ld_outd_o,
  input logic              inc_pc_o,
  input logic              exec_start_o,
  input logic [STEP_W-1:0] step_o,
  input logic [NSTEP-1:0]  t_o,
  input logic              stopped_o
);
  p_onehot_t_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(t_o) == 1);

  p_t_matches_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_o[step_o]);

  p_halt_loop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stopped_o && t_o[3]) |=> (step_o == '0));

  p_halt_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_o |-> (!inc_pc_o && !ld_ir_o));

  p_inc_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_pc_o |=> !inc_pc_o);

  p_start_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_start_o |=> !exec_start_o);

  p_one_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ld_ar_o, ld_ir_o, ld_dr_o, ld_outd_o}));

  p_start_at_wait_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_start_o |-> t_o[NSTEP-1]);

  p_wait_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_o[NSTEP-1] && !exec_done_i) |=> t_o[NSTEP-1]);
endmodule

bind icycle_ctrl icycle_ctrl_chk #(.STEP_W(STEP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .exec_done_i (exec_done_i),
  .ld_ar_o     (ld_ar_o),
  .ld_ir_o     (ld_ir_o),
  .ld_dr_o     (ld_dr_o),
  .ld_outd_o   (ld_outd_o),
  .inc_pc_o    (inc_pc_o),
  .exec_start_o(exec_start_o),
  .step_o      (step_o),
  .t_o         (t_o),
  .stopped_o   (stopped_o)
);

// File: tb/sim_icycle_ctrl.sv
`timescale 1ns/1ps
module sim_icycle_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt = 1'b0;
  logic        exec_done;
  logic [1:0]  bus_sel;
  logic        ld_ar, ld_ir, ld_dr, ld_outd, inc_pc, mem_rd, exec_start, stopped;
  logic [3:0]  step;
  logic [15:0] t;

  logic [7:0] mem [256];
  logic [7:0] ar, pc, ir, dr, outd, mem_q, outa, bus, pc_seed;
  logic       seed_ld;
  logic [1:0] ex_cnt;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  icycle_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .halt_i(halt), .ir_i(ir), .exec_done_i(exec_done),
    .bus_sel_o(bus_sel), .ld_ar_o(ld_ar), .ld_ir_o(ld_ir), .ld_dr_o(ld_dr),
    .ld_outd_o(ld_outd), .inc_pc_o(inc_pc), .mem_rd_o(mem_rd),
    .exec_start_o(exec_start), .step_o(step), .t_o(t), .stopped_o(stopped)
  );

  // datapath and executor stub
  always_comb begin
    case (bus_sel)
      2'd0:    bus = outa;
      2'd1:    bus = pc;
      2'd2:    bus = mem_q;
      default: bus = 8'h00;
    endcase
  end
  assign exec_done = (ex_cnt == 2'd1);

  initial begin ar = 0; pc = 0; ir = 0; dr = 0; outd = 0; mem_q = 0; ex_cnt = 0; end

  always @(posedge clk) begin
    if (seed_ld) pc <= pc_seed;
    else if (inc_pc) pc <= pc + 8'd1;
    if (mem_rd)  mem_q <= mem[ar];
    if (ld_ar)   ar <= bus;
    if (ld_ir)   ir <= bus;
    if (ld_dr)   dr <= bus;
    if (ld_outd) outd <= bus;
    if (exec_start) ex_cnt <= 2'd3;
    else if (ex_cnt != 0) ex_cnt <= ex_cnt - 2'd1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // continuous protocol monitor
  always @(negedge clk) begin
    if (rst_n && exec_start) chk("R9 start at step 15", step, 15);
    if (rst_n && (int'(ld_ar) + int'(ld_ir) + int'(ld_dr) + int'(ld_outd) > 1))
      chk("R8 single load", 1, 0);
  end

  task automatic wait_done(input string req);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (exec_done) return;
    end
    chk({req, " done timeout"}, 0, 1);
  endtask

  task automatic mem_init();
    for (int a = 0; a < 256; a++) mem[a] = 8'((a * 13 + 7) & 255);
  endtask

  // {start pc, opcode, second byte, display address}
  localparam logic [31:0] VEC [6] = '{
    32'h00_41_00_80,  // register reference
    32'h10_05_90_81,  // direct
    32'h20_85_A0_82,  // indirect
    32'hFE_02_B0_10,  // direct, second byte at 0xFF
    32'h30_C3_00_31,  // register reference with bit 7 set
    32'hFF_86_C0_FF   // indirect, PC wraps
  };

  initial begin
    logic [7:0] sp, op, b2, da, ea;
    seed_ld = 1'b1; pc_seed = 8'h00; outa = 8'h00;
    mem_init();
    repeat (3) @(negedge clk);
    // reset state
    chk("R1 reset step", step, 0);
    chk("R1 reset t", t, 16'h0001);
    chk("R8 reset strobes", {ld_ar, ld_ir, ld_dr, ld_outd, inc_pc, mem_rd, exec_start}, 0);
    chk("R2 reset bus none", bus_sel, 3);
    chk("R7 reset not stopped", stopped, 0);

    foreach (VEC[k]) begin
      {sp, op, b2, da} = VEC[k];
      rst_n = 1'b0; seed_ld = 1'b1; pc_seed = sp; outa = da;
      mem_init();
      mem[sp] = op;
      mem[8'(sp + 1)] = b2;
      @(negedge clk);
      rst_n = 1'b1; seed_ld = 1'b0;
      wait_done("R1");
      chk("R2 display", outd, mem[da]);
      chk("R3 opcode in IR", ir, op);
      if (op[6]) begin
        chk("R4 reg ref PC+1", pc, 8'(sp + 1));
      end else begin
        ea = op[7] ? mem[b2] : b2;
        chk(op[7] ? "R6 indirect AR" : "R5 direct AR", ar, ea);
        chk(op[7] ? "R6 indirect DR" : "R5 direct DR", dr, mem[ea]);
        chk(op[7] ? "R6 indirect PC" : "R5 direct PC", pc, 8'(sp + 2));
      end
      @(negedge clk);
      chk("R1 cleared after done", step, 0);
    end

    // halt: one instruction runs, then only display steps
    rst_n = 1'b0; seed_ld = 1'b1; pc_seed = 8'h40; outa = 8'h12;
    mem_init();
    mem[8'h40] = 8'h41; mem[8'h41] = 8'h41;
    @(negedge clk);
    rst_n = 1'b1; seed_ld = 1'b0; halt = 1'b1;
    wait_done("R7");
    @(negedge clk);
    chk("R7 stop flag set", stopped, 1);
    chk("R7 first instr ran", pc, 8'h41);
    outa = 8'h55;
    repeat (40) @(negedge clk);
    chk("R7 PC frozen", pc, 8'h41);
    chk("R7 stays stopped", stopped, 1);
    chk("R2 display while stopped", outd, mem[8'h55]);
    chk("R7 only display steps", (step <= 3) ? 1 : 0, 1);
    halt = 1'b0;
    wait_done("R7 resume");
    chk("R7 resumed PC", pc, 8'h42);
    chk("R7 flag cleared", stopped, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule